// File: doc/BRIEF.md
# Iterative Lightweight Hash Core

This core computes a 128-bit digest over a stream of 32-bit words for area-limited devices such as passive tags. It keeps a 160-bit chaining state: one 32-bit carry word and four 32-bit fold words. For each word accepted, two working registers are seeded from the carry word. A pair of independent filter rounds is run 32 times, one round per clock with both filters in parallel. A 4 x 8 nested expansion then mixes the two working registers and folds them into one fold word at the end of each inner pass. At the end the carry word is refreshed from the working registers.

The caller pads the message and streams the words with a valid/ready handshake, flagging the final word. An init pulse clears the state and abandons any work in progress. When the word flagged as final has been compressed, a one-cycle done pulse marks the digest as valid. The digest then stays unchanged until further words are accepted or init is pulsed.

The control FSM has five named states. ST_IDLE waits for a word; on accept it goes to ST_FILT. ST_FILT runs the filter rounds and moves to ST_EXP after the last round. ST_EXP runs inner expansion steps and moves to ST_FOLD after the eighth step. ST_FOLD folds into one fold word and then returns to ST_EXP, or, after the fourth fold, moves on to ST_CHAIN. ST_CHAIN updates the carry word and returns to ST_IDLE. Init forces ST_IDLE from any state. Two counters serve all three loops: a round counter shared by the filter loop and the inner loop, and a fold index for the outer loop.

Top module: `lwhash_core`

## Requirements
- R1: After reset or an init pulse, the digest is all zero, ready is high and done is low.
- R2: A word is taken at a rising clock edge where valid and ready are high and init is low. Ready then stays low for exactly 69 cycles: 32 filter, 4 x (8 expansion + 1 fold), and 1 chaining.
- R3: On accept, both working registers x and y load the carry word. Each of 32 rounds then sets x := (x<<1) + ((x+m)>>1) and y := (y<<1) + (y>>1) + y + m, where m is the accepted word. Shifts are logical and sums are modulo 2^32.
- R4: Each of the 8 inner expansion steps first sets t := x ^ ((y+x)>>3) and x := ((((t>>2)+t)>>2) + (t<<3) + (t>>1)) ^ 32'h736B83DC. Using that new x, it then sets u := y ^ ((y^x)>>1) and y := (u>>4) + (u>>3) + (u<<3) + u.
- R5: After inner pass j (j = 0..3, in ascending order), fold word j becomes (fold word j + x) XOR y.
- R6: After the fourth fold, the carry word becomes x + y. The next word, without an init, starts from this value.
- R7: The digest is {fold3, fold2, fold1, fold0}, with fold word 0 in bits 31:0.
- R8: Done is high for exactly one cycle, in the first cycle after compression of a word whose last flag was high. It stays low for words accepted with the last flag low.
- R9: While idle with valid low, the digest and ready do not change.
- R10: Init at any time, including mid-compression, abandons the word, clears the state and returns to idle on the next cycle.
- R11: Valid, word and last are ignored while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Clears the chaining state and aborts work |
| word_i | input | 32 | Message word |
| word_valid_i | input | 1 | Message word is present |
| word_last_i | input | 1 | Message word is the final one |
| word_ready_o | output | 1 | Core can accept a word |
| digest_o | output | 128 | Digest {fold3, fold2, fold1, fold0} |
| done_o | output | 1 | One-cycle pulse: digest valid |

## Verification
A walking-one sweep over all 32 bit positions, run as single-word messages, checks that every message bit reaches the digest through the filter and expansion arithmetic. All-zero, all-one and alternating words, and an incrementing multi-word sequence, check carry propagation in the sums and chaining between words. Messages continued without an init separate correct carry-word reuse from a design that reseeds from zero. Holding a conflicting word and last flag on the inputs during compression, and an init pulse in the middle of a word, tell a proper handshake and abort apart from designs that sample the inputs while busy or keep partial state.

// File: rtl/lwh_pkg.sv
package lwh_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILT,
        ST_EXP,
        ST_FOLD,
        ST_CHAIN
    } phase_e;

    // filter round for the x register
    function automatic word_t mix_x(input word_t x, input word_t m);
        word_t s;
        s = x + m;
        return (x << 1) + (s >> 1);
    endfunction

    // filter round for the y register
    function automatic word_t mix_y(input word_t y, input word_t m);
        return (y << 1) + (y >> 1) + y + m;
    endfunction

    // first half of an expansion step (updates x)
    function automatic word_t spread_x(input word_t x, input word_t y, input word_t k);
        word_t s;
        word_t t;
        word_t q;
        s = y + x;
        t = x ^ (s >> 3);
        q = (t >> 2) + t;
        return ((q >> 2) + (t << 3) + (t >> 1)) ^ k;
    endfunction

    // second half of an expansion step (updates y from the new x)
    function automatic word_t spread_y(input word_t x_new, input word_t y);
        word_t u;
        u = y ^ ((y ^ x_new) >> 1);
        return (u >> 4) + (u >> 3) + (u << 3) + u;
    endfunction

endpackage

// File: rtl/lwh_ctrl.sv
module lwh_ctrl
    import lwh_pkg::*;
#(
    parameter int unsigned FILT_ROUNDS = 32,
    parameter int unsigned EXP_OUTER   = 4,
    parameter int unsigned EXP_INNER   = 8,
    parameter int unsigned RND_W       = 5,
    parameter int unsigned JW          = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          valid_i,
    input  logic          last_i,
    output logic          ready_o,
    output logic          load_o,
    output logic          filt_o,
    output logic          exp_o,
    output logic          fold_o,
    output logic          chain_o,
    output logic          clr_o,
    output logic [JW-1:0] sel_o,
    output logic          done_o
);

    localparam logic [RND_W-1:0] FILT_LAST  = RND_W'(FILT_ROUNDS - 1);
    localparam logic [RND_W-1:0] INNER_LAST = RND_W'(EXP_INNER - 1);
    localparam logic [JW-1:0]    OUTER_LAST = JW'(EXP_OUTER - 1);

    phase_e            st;
    phase_e            nxt;
    logic [RND_W-1:0]  rnd;
    logic [JW-1:0]     jdx;
    logic              last_q;

    // next-state selection
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (valid_i)           nxt = ST_FILT;
            ST_FILT:  if (rnd == FILT_LAST)  nxt = ST_EXP;
            ST_EXP:   if (rnd == INNER_LAST) nxt = ST_FOLD;
            ST_FOLD:  nxt = (jdx == OUTER_LAST) ? ST_CHAIN : ST_EXP;
            ST_CHAIN: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (init_i) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // strobes towards the datapath and state store
    always_comb begin
        ready_o = (st == ST_IDLE);
        load_o  = (st == ST_IDLE)  && valid_i && !init_i;
        filt_o  = (st == ST_FILT)  && !init_i;
        exp_o   = (st == ST_EXP)   && !init_i;
        fold_o  = (st == ST_FOLD)  && !init_i;
        chain_o = (st == ST_CHAIN) && !init_i;
        clr_o   = init_i;
        sel_o   = jdx;
    end

    // two shared loop counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd <= '0;
            jdx <= '0;
        end else if (init_i || load_o) begin
            rnd <= '0;
            jdx <= '0;
        end else begin
            if (filt_o) rnd <= (rnd == FILT_LAST)  ? '0 : rnd + 1'b1;
            if (exp_o)  rnd <= (rnd == INNER_LAST) ? '0 : rnd + 1'b1;
            if (fold_o && (jdx != OUTER_LAST)) jdx <= jdx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            if (load_o) last_q <= last_i;
            done_o <= chain_o && last_q;
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !ready_o);

    p_init_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (ready_o && !done_o));

    p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, filt_o, exp_o, fold_o, chain_o}));

endmodule

// File: rtl/lwh_datapath.sv
module lwh_datapath
    import lwh_pkg::*;
#(
    parameter logic [31:0] XOR_K = 32'h736B83DC
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  filt_i,
    input  logic  exp_i,
    input  word_t seed_i,
    input  word_t word_i,
    output word_t x_o,
    output word_t y_o
);

    word_t x_q;
    word_t y_q;
    word_t m_q;
    word_t x_nx;

    assign x_nx = spread_x(x_q, y_q, XOR_K);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            m_q <= '0;
        end else if (load_i) begin
            x_q <= seed_i;
            y_q <= seed_i;
            m_q <= word_i;
        end else if (filt_i) begin
            x_q <= mix_x(x_q, m_q);
            y_q <= mix_y(y_q, m_q);
        end else if (exp_i) begin
            x_q <= x_nx;
            y_q <= spread_y(x_nx, y_q);
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

    p_work_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || filt_i || exp_i) |=> $stable({x_q, y_q}));

endmodule

// File: rtl/lwh_state.sv
module lwh_state
    import lwh_pkg::*;
#(
    parameter int unsigned EXP_OUTER = 4,
    parameter int unsigned JW        = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        fold_i,
    input  logic [JW-1:0]               sel_i,
    input  logic                        chain_i,
    input  word_t                       x_i,
    input  word_t                       y_i,
    output word_t                       carry_o,
    output logic [WORD_W*EXP_OUTER-1:0] digest_o
);

    word_t carry_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       carry_q <= '0;
        else if (clr_i)   carry_q <= '0;
        else if (chain_i) carry_q <= x_i + y_i;
    end

    assign carry_o = carry_q;

    for (genvar g = 0; g < EXP_OUTER; g++) begin : g_fold
        word_t s_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           s_q <= '0;
            else if (clr_i)                       s_q <= '0;
            else if (fold_i && (sel_i == JW'(g))) s_q <= (s_q + x_i) ^ y_i;
        end
        assign digest_o[g*WORD_W +: WORD_W] = s_q;
    end

    p_digest_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fold_i && !clr_i) |=> $stable(digest_o));

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (digest_o == '0 && carry_q == '0));

endmodule

// File: rtl/lwhash_core.sv
module lwhash_core
    import lwh_pkg::*;
#(
    parameter int unsigned FILT_ROUNDS = 32,
    parameter int unsigned EXP_OUTER   = 4,
    parameter int unsigned EXP_INNER   = 8,
    parameter logic [31:0] XOR_K       = 32'h736B83DC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        init_i,
    input  logic [31:0]                 word_i,
    input  logic                        word_valid_i,
    input  logic                        word_last_i,
    output logic                        word_ready_o,
    output logic [WORD_W*EXP_OUTER-1:0] digest_o,
    output logic                        done_o
);

    localparam int unsigned RND_MAX = (FILT_ROUNDS > EXP_INNER) ? FILT_ROUNDS : EXP_INNER;
    localparam int unsigned RND_W   = (RND_MAX > 1) ? $clog2(RND_MAX) : 1;
    localparam int unsigned JW      = (EXP_OUTER > 1) ? $clog2(EXP_OUTER) : 1;

    logic          load;
    logic          filt;
    logic          expd;
    logic          fold;
    logic          chain;
    logic          clr;
    logic [JW-1:0] sel;
    word_t         x_w;
    word_t         y_w;
    word_t         carry_w;

    lwh_ctrl #(
        .FILT_ROUNDS (FILT_ROUNDS),
        .EXP_OUTER   (EXP_OUTER),
        .EXP_INNER   (EXP_INNER),
        .RND_W       (RND_W),
        .JW          (JW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_i),
        .valid_i (word_valid_i),
        .last_i  (word_last_i),
        .ready_o (word_ready_o),
        .load_o  (load),
        .filt_o  (filt),
        .exp_o   (expd),
        .fold_o  (fold),
        .chain_o (chain),
        .clr_o   (clr),
        .sel_o   (sel),
        .done_o  (done_o)
    );

    lwh_datapath #(
        .XOR_K (XOR_K)
    ) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .filt_i (filt),
        .exp_i  (expd),
        .seed_i (carry_w),
        .word_i (word_i),
        .x_o    (x_w),
        .y_o    (y_w)
    );

    lwh_state #(
        .EXP_OUTER (EXP_OUTER),
        .JW        (JW)
    ) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .fold_i   (fold),
        .sel_i    (sel),
        .chain_i  (chain),
        .x_i      (x_w),
        .y_i      (y_w),
        .carry_o  (carry_w),
        .digest_o (digest_o)
    );

    p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> word_ready_o);

    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_ready_o && !init_i && !fold) |=> $stable(digest_o));

endmodule

// File: tb/tb_lwhash_core.sv
`timescale 1ns/1ps
module tb_lwhash_core;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         init;
    logic [31:0]  word;
    logic         valid;
    logic         last;
    logic         ready;
    logic [127:0] digest;
    logic         done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [31:0] ma0;
    logic [31:0] ms [4];

    always #4 clk = ~clk;

    lwhash_core dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init),
        .word_i       (word),
        .word_valid_i (valid),
        .word_last_i  (last),
        .word_ready_o (ready),
        .digest_o     (digest),
        .done_o       (done)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model_digest();
        return {ms[3], ms[2], ms[1], ms[0]};
    endfunction

    // reference compression written from R3..R6
    task automatic model_word(input logic [31:0] m);
        logic [31:0] x, y, s, t, q, u;
        x = ma0;
        y = ma0;
        for (int r = 0; r < 32; r++) begin
            s = x + m;
            x = (x << 1) + (s >> 1);
            y = (y << 1) + (y >> 1) + y + m;
        end
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 8; i++) begin
                s = y + x;
                t = x ^ (s >> 3);
                q = (t >> 2) + t;
                x = ((q >> 2) + (t << 3) + (t >> 1)) ^ 32'h736B83DC;
                u = y ^ ((y ^ x) >> 1);
                y = (u >> 4) + (u >> 3) + (u << 3) + u;
            end
            ms[j] = (ms[j] + x) ^ y;
        end
        ma0 = x + y;
    endtask

    task automatic model_clear();
        ma0 = '0;
        for (int j = 0; j < 4; j++) ms[j] = '0;
    endtask

    task automatic do_init();
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        model_clear();
        check("R1 R10 digest after init", digest, 128'h0);
        check("R1 ready after init", {127'h0, ready}, 128'h1);
        check("R1 done after init", {127'h0, done}, 128'h0);
    endtask

    task automatic send(input logic [31:0] w, input logic lst, input bit junk);
        int lowcnt;
        @(negedge clk);
        valid = 1'b1;
        word  = w;
        last  = lst;
        @(negedge clk);
        if (junk) begin
            word = ~w ^ 32'h5A5A_C3C3;
            last = ~lst;
        end else begin
            valid = 1'b0;
        end
        lowcnt = 0;
        while (!ready) begin
            lowcnt++;
            @(negedge clk);
        end
        valid = 1'b0;
        model_word(w);
        check("R2 ready low cycles", 128'(lowcnt), 128'd69);
        check("R8 done after word", {127'h0, done}, {127'h0, lst});
        if (lst) check("R3 R4 R5 R6 R7 R11 digest", digest, model_digest());
        @(negedge clk);
        check("R8 done single cycle", {127'h0, done}, 128'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        rst_n = 1'b0;
        init  = 1'b0;
        word  = '0;
        valid = 1'b0;
        last  = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        check("R1 reset digest", digest, 128'h0);
        check("R1 reset ready", {127'h0, ready}, 128'h1);
        check("R1 reset done", {127'h0, done}, 128'h0);
        rst_n = 1'b1;

        // single zero word
        do_init();
        send(32'h0, 1'b1, 1'b0);

        // walking one, each a one-word message; odd ones hold junk on the inputs (R11)
        for (int b = 0; b < 32; b++) begin
            do_init();
            send(32'h1 << b, 1'b1, bit'(b & 1));
        end

        // carry-stressing patterns
        do_init();
        send(32'hFFFF_FFFF, 1'b1, 1'b0);
        do_init();
        send(32'hAAAA_5555, 1'b0, 1'b1);
        send(32'h5555_AAAA, 1'b0, 1'b0);
        send(32'h8000_0001, 1'b1, 1'b1);

        // incrementing multi-word message, then continue without init (R6)
        do_init();
        for (int k = 0; k < 8; k++) send(32'h0101_0101 * (k + 1), (k == 7), 1'b0);
        send(32'hDEAD_BEEF, 1'b1, 1'b0);

        // idle hold (R9)
        held = digest;
        repeat (12) @(negedge clk);
        check("R9 digest held while idle", digest, held);
        check("R9 ready held while idle", {127'h0, ready}, 128'h1);
        check("R9 no done while idle", {127'h0, done}, 128'h0);

        // init in the middle of a word (R10)
        @(negedge clk);
        valid = 1'b1;
        word  = 32'h1234_5678;
        last  = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 busy before abort", {127'h0, ready}, 128'h0);
        do_init();
        repeat (80) @(negedge clk);
        check("R10 no done after abort", {127'h0, done}, 128'h0);
        check("R10 digest stays clear", digest, 128'h0);
        send(32'hCAFE_F00D, 1'b1, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule